// File: doc/BRIEF.md
# Colour Subcarrier Phase Synthesizer

This block generates the running phase of the colour subcarrier for standard-definition composite video. A 32-bit phase accumulator advances by a frequency increment on every pixel clock, and its upper bits drive an external sine lookup. The increment comes from four byte-wide registers. Software writes them one byte at a time, and the block applies the new word only once all four bytes have arrived. The increment is chosen as round(2^32 × subcarrier cycles per line ÷ clock periods per line). For NTSC at 1716 clocks and 227.5 subcarrier cycles per line, this gives 0x21F07C1F, which is also the value after reset.

A clear input zeroes the phase. An optional lock mode follows a companion video decoder. A serial frame from the decoder carries a 22-bit increment and a 14-bit phase. While lock mode is on, the received 22 bits replace the upper part of the increment, and each completed frame realigns the accumulator to the received phase. A line-sign flag alternates on every line start while PAL is selected and stays 0 otherwise.

Top module: `subcarrier_dds`

## Requirements
- R1: After synchronous reset, the phase is 0, the line flag is 0 and the increment is RESET_WORD (default 0x21F07C1F).
- R2: On each clock edge without clear or load, the accumulator adds the effective increment modulo 2^32, wrapping silently.
- R3: Byte register select 0 holds increment bits 7:0, select 1 bits 15:8, select 2 bits 23:16 and select 3 bits 31:24.
- R4: The staged bytes become the increment together on the edge that completes a write of all four selects since the last update. Writes may come in any order. Until then the old increment stays in use.
- R5: When `dds_clear` is high at an edge, the accumulator is 0 after that edge. Clear takes priority over load and accumulate.
- R6: A serial frame is 36 bits, sampled when `ser_valid` is high, MSB first. `ser_first` marks the first bit. The first 22 bits are the lock increment and the last 14 bits are the lock phase.
- R7: While `lock_en` is high, the effective increment is {lock increment, register bits 9:0}.
- R8: While `lock_en` is high, one edge after the edge that samples a frame's last bit, the accumulator holds {lock phase, 18 zero bits}.
- R9: While `lock_en` is low, received frames leave the phase and the increment untouched.
- R10: While `pal_mode` is high, the line flag inverts at each edge where `line_start` is high. Otherwise it holds (0 = normal line, 1 = inverted).
- R11: While `pal_mode` is low, the line flag is 0 after every edge, and `line_start` has no effect on it.
- R12: `phase_out` equals the top PHASE_OUT_W bits of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Byte register write strobe |
| reg_sel | input | 2 | Byte register select (0 = least significant) |
| reg_wdata | input | 8 | Byte register write data |
| dds_clear | input | 1 | Zero the phase accumulator |
| lock_en | input | 1 | Enable lock mode |
| ser_valid | input | 1 | Serial lock bit strobe |
| ser_first | input | 1 | Marks the first bit of a lock frame |
| ser_bit | input | 1 | Serial lock data bit |
| pal_mode | input | 1 | PAL selected (line flag active) |
| line_start | input | 1 | Start-of-line pulse |
| phase_out | output | PHASE_OUT_W (10) | Upper accumulator bits for the sine lookup |
| pal_flag | output | 1 | Line sign: 0 normal, 1 inverted |

## Verification
The bench builds the block with PHASE_OUT_W set to 32, so the whole accumulator is visible at the output. This lets each check compare an exact 32-bit phase rather than a truncated one. The low 10 register bits that join the lock increment, the 18 zero bits below a loaded lock phase, and carries lost at the 2^32 wrap all become directly observable. All other parameters stay at their defaults, so the frame length, field split and reset word match normal use.

// File: rtl/sc_dds_pkg.sv
package sc_dds_pkg;
  localparam int ACC_W      = 32;
  localparam int BYTE_W     = 8;
  localparam int LOCK_W     = 22;
  localparam int LPH_W      = 14;
  localparam logic [31:0] NTSC_WORD = 32'h21F07C1F;
endpackage

// File: rtl/freq_word_regs.sv
module freq_word_regs #(
  parameter int ACC_W = 32,
  parameter int BYTE_W = 8,
  parameter logic [ACC_W-1:0] RESET_WORD = '0,
  localparam int NB = ACC_W / BYTE_W,
  localparam int SW = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SW-1:0]     sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [ACC_W-1:0]  freq_word
);
  logic [NB-1:0][BYTE_W-1:0] stage, stage_n;
  logic [NB-1:0]             seen, seen_n;

  always_comb begin
    stage_n = stage;
    seen_n  = seen;
    if (we) begin
      stage_n[sel] = wdata;
      seen_n[sel]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage     <= '0;
      seen      <= '0;
      freq_word <= RESET_WORD;
    end else begin
      stage <= stage_n;
      if (&seen_n) begin
        freq_word <= stage_n;
        seen      <= '0;
      end else begin
        seen <= seen_n;
      end
    end
  end

  // R4: the word only moves on the edge that takes a write
  assert_no_torn_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(freq_word) |-> $past(we));
endmodule

// File: rtl/lock_serial_rx.sv
module lock_serial_rx #(
  parameter int LOCK_W = 22,
  parameter int LPH_W = 14,
  localparam int FRAME_W = LOCK_W + LPH_W,
  localparam int CW = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              first,
  input  logic              sbit,
  output logic              frame_done,
  output logic [LOCK_W-1:0] lock_inc,
  output logic [LPH_W-1:0]  lock_phase
);
  logic [FRAME_W-1:0] sh, sh_n;
  logic [CW-1:0]      cnt, base;

  always_comb begin
    sh_n = {sh[FRAME_W-2:0], sbit};
    base = first ? '0 : cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh         <= '0;
      cnt        <= '0;
      frame_done <= 1'b0;
      lock_inc   <= '0;
      lock_phase <= '0;
    end else begin
      frame_done <= 1'b0;
      if (valid) begin
        sh <= sh_n;
        if (base == CW'(FRAME_W - 1)) begin
          frame_done <= 1'b1;
          lock_inc   <= sh_n[FRAME_W-1 -: LOCK_W];
          lock_phase <= sh_n[LPH_W-1:0];
          cnt        <= '0;
        end else begin
          cnt <= base + 1'b1;
        end
      end
    end
  end

  // R6: a frame completes as a single-cycle event
  assert_single_done_R6: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  // R6: bit counter never runs past the frame length
  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(FRAME_W));
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int ACC_W = 32,
  parameter int LPH_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [LPH_W-1:0] load_phase,
  input  logic [ACC_W-1:0] incr,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst || clear)
      acc <= '0;
    else if (load)
      acc <= {load_phase, {(ACC_W-LPH_W){1'b0}}};
    else
      acc <= acc + incr;
  end

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
    clear |=> acc == '0);
  assert_load_phase_R8: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> (acc[ACC_W-1 -: LPH_W] == $past(load_phase)) &&
                         (acc[ACC_W-LPH_W-1:0] == '0));
  assert_wrap_add_R2: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load) |=> acc == $past(acc) + $past(incr));
endmodule

// File: rtl/subcarrier_dds.sv
module subcarrier_dds
  import sc_dds_pkg::*;
#(
  parameter int PHASE_OUT_W = 10,
  parameter logic [ACC_W-1:0] RESET_WORD = NTSC_WORD,
  localparam int NB = ACC_W / BYTE_W,
  localparam int SW = $clog2(NB),
  localparam int LOW_W = ACC_W - LOCK_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [SW-1:0]          reg_sel,
  input  logic [BYTE_W-1:0]      reg_wdata,
  input  logic                   dds_clear,
  input  logic                   lock_en,
  input  logic                   ser_valid,
  input  logic                   ser_first,
  input  logic                   ser_bit,
  input  logic                   pal_mode,
  input  logic                   line_start,
  output logic [PHASE_OUT_W-1:0] phase_out,
  output logic                   pal_flag
);
  logic [ACC_W-1:0]  freq_word, inc_eff, acc;
  logic              frame_done;
  logic [LOCK_W-1:0] lock_inc;
  logic [LPH_W-1:0]  lock_phase;

  freq_word_regs #(.ACC_W(ACC_W), .BYTE_W(BYTE_W), .RESET_WORD(RESET_WORD)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .freq_word(freq_word));

  lock_serial_rx #(.LOCK_W(LOCK_W), .LPH_W(LPH_W)) u_rx (
    .clk(clk), .rst(rst), .valid(ser_valid), .first(ser_first), .sbit(ser_bit),
    .frame_done(frame_done), .lock_inc(lock_inc), .lock_phase(lock_phase));

  assign inc_eff = lock_en ? {lock_inc, freq_word[LOW_W-1:0]} : freq_word;

  phase_accum #(.ACC_W(ACC_W), .LPH_W(LPH_W)) u_acc (
    .clk(clk), .rst(rst), .clear(dds_clear), .load(lock_en && frame_done),
    .load_phase(lock_phase), .incr(inc_eff), .acc(acc));

  assign phase_out = acc[ACC_W-1 -: PHASE_OUT_W];

  always_ff @(posedge clk) begin
    if (rst || !pal_mode)
      pal_flag <= 1'b0;
    else if (line_start)
      pal_flag <= ~pal_flag;
  end

  assert_ntsc_flag_R11: assert property (@(posedge clk) disable iff (rst)
    !pal_mode |=> !pal_flag);
  assert_pal_toggle_R10: assert property (@(posedge clk) disable iff (rst)
    (pal_mode && line_start) |=> pal_flag != $past(pal_flag));
  assert_pal_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (pal_mode && !line_start) |=> $stable(pal_flag));
endmodule

// File: tb/subcarrier_dds_test.sv
module subcarrier_dds_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 0, dds_clear = 0, lock_en = 0;
  logic ser_valid = 0, ser_first = 0, ser_bit = 0;
  logic pal_mode = 0, line_start = 0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic [31:0] phase_out;
  logic pal_flag;

  int checks = 0, failures = 0;
  int n_since = 0;

  always #10 clk = ~clk;

  subcarrier_dds #(.PHASE_OUT_W(32)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .dds_clear(dds_clear), .lock_en(lock_en), .ser_valid(ser_valid),
    .ser_first(ser_first), .ser_bit(ser_bit), .pal_mode(pal_mode),
    .line_start(line_start), .phase_out(phase_out), .pal_flag(pal_flag));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    n_since++;
  endtask

  task automatic clear_acc();
    dds_clear = 1'b1;
    step();
    dds_clear = 1'b0;
    n_since = 0;
  endtask

  task automatic wr_byte(input int sel, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic run_and_check(input string req, input int n, input logic [31:0] inc);
    clear_acc();
    check(req, phase_out, 32'h0);
    for (int i = 0; i < n; i++) step();
    check(req, phase_out, 32'(n) * inc);
  endtask

  task automatic send_frame(input logic [21:0] inc22, input logic [13:0] ph14);
    logic [35:0] fr;
    fr = {inc22, ph14};
    for (int i = 35; i >= 0; i--) begin
      ser_valid = 1'b1; ser_first = (i == 35); ser_bit = fr[i];
      step();
    end
    ser_valid = 1'b0; ser_first = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 phase", phase_out, 32'h0);
    check("R1 flag", {31'b0, pal_flag}, 32'h0);
    n_since = 0;
    for (int i = 0; i < 7; i++) step();
    check("R1 reset word", phase_out, 32'd7 * 32'h21F07C1F);
  endtask

  task automatic t_bytes();
    wr_byte(0, 8'h78); wr_byte(1, 8'h56); wr_byte(2, 8'h34); wr_byte(3, 8'h12);
    run_and_check("R3 byte order", 5, 32'h12345678);
    wr_byte(2, 8'hCC); wr_byte(0, 8'hAA); wr_byte(3, 8'hDD); wr_byte(1, 8'hBB);
    run_and_check("R4 any order", 3, 32'hDDCCBBAA);
  endtask

  task automatic t_torn();
    wr_byte(0, 8'h01); wr_byte(1, 8'h02); wr_byte(2, 8'h03);
    run_and_check("R4 partial ignored", 4, 32'hDDCCBBAA);
    wr_byte(3, 8'h04);
    run_and_check("R4 commit", 4, 32'h04030201);
  endtask

  task automatic t_wrap();
    wr_byte(3, 8'hF0); wr_byte(2, 8'h00); wr_byte(1, 8'h00); wr_byte(0, 8'h01);
    run_and_check("R2 wrap", 3, 32'hF0000001);
    check("R12 top bits", phase_out, 32'hD0000003);
  endtask

  task automatic t_clear_mid();
    for (int i = 0; i < 5; i++) step();
    clear_acc();
    check("R5 clear", phase_out, 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] inc;
    wr_byte(0, 8'h1F); wr_byte(1, 8'h7C); wr_byte(2, 8'hF0); wr_byte(3, 8'h21);
    lock_en = 1'b1;
    send_frame(22'h155555, 14'h1ABC);
    step();
    check("R8 lock phase load", phase_out, {14'h1ABC, 18'h0});
    inc = {22'h155555, 10'h01F};
    for (int i = 0; i < 6; i++) step();
    check("R7 R6 lock increment", phase_out, {14'h1ABC, 18'h0} + 32'd6 * inc);
    run_and_check("R7 lock slope", 9, inc);
    lock_en = 1'b0;
    run_and_check("R7 lock off", 4, 32'h21F07C1F);
  endtask

  task automatic t_lock_off_frame();
    clear_acc();
    send_frame(22'h3FFFFF, 14'h2222);
    for (int i = 0; i < 3; i++) step();
    check("R9 frame ignored", phase_out, 32'(n_since) * 32'h21F07C1F);
  endtask

  task automatic t_pal();
    pal_mode = 1'b1;
    step();
    check("R10 start", {31'b0, pal_flag}, 32'h0);
    line_start = 1'b1; step(); line_start = 1'b0;
    check("R10 toggle 1", {31'b0, pal_flag}, 32'h1);
    for (int i = 0; i < 3; i++) step();
    check("R10 hold", {31'b0, pal_flag}, 32'h1);
    line_start = 1'b1; step(); line_start = 1'b0;
    check("R10 toggle 0", {31'b0, pal_flag}, 32'h0);
    line_start = 1'b1; step(); line_start = 1'b0;
    check("R10 toggle again", {31'b0, pal_flag}, 32'h1);
    pal_mode = 1'b0;
    step();
    check("R11 ntsc clears", {31'b0, pal_flag}, 32'h0);
    line_start = 1'b1; step(); line_start = 1'b0;
    check("R11 line_start ignored", {31'b0, pal_flag}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bytes();
    t_torn();
    t_wrap();
    t_clear_mid();
    t_lock();
    t_lock_off_frame();
    t_pal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule